// File: doc/BRIEF.md
# Dual-Reload PWM Down-Counter Timer

This block is an 8-bit down counter that runs from a slow count source. It has two reload values. The low-interval value sets the length of the low phase and the high-interval value sets the length of the high phase. It has two modes:

- **Interval timer.** With PWM disabled, the counter reloads from the low value on every underflow. Each underflow raises a sticky interrupt flag.
- **PWM generator.** With PWM enabled, the counter alternates between a low phase and a high phase, and drives a waveform with those phase lengths.

There are three PWM options. A stretch bit lengthens each high phase by half a source period. A gating input lets another timer's underflow pulses switch the waveform between visible and masked. A stop request that arrives during a high phase is held off until that phase has finished.

The count source comes in as one of two level signals, chosen by a select pin and sampled on the system clock. A count event is a rising transition of the selected level. In stretch mode the counting edge alternates after each stretched high phase.

All pins are plain control and status signals: single-cycle command strobes, level mode bits, and registered outputs. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `pwm_reload_timer`

## Requirements
- R1: A pulse on `wr_load` writes `wr_data` into both the counter and the low-interval register; `cnt_value` shows it one cycle later. A pulse on `reload` copies the low-interval register into the counter. A pulse on `wr_high` writes only the high-interval register and leaves `cnt_value` unchanged.
- R2: The counter does not move while `run` is 0. While `run` is 1, it decrements on each rising transition of the selected source: `src_a` when `src_sel` is 0, `src_b` when `src_sel` is 1. Transitions on the other source have no effect.
- R3: With `pwm_en` = 0 and low value n, an underflow happens on the count event that finds the counter at zero. The counter then reloads n, and `underflow` pulses for one cycle. Consecutive pulses are therefore n+1 source periods apart, for n from 0 to 255.
- R4: `irq_flag` is set in the same cycle that `underflow` pulses, and stays set until an `irq_ack` pulse. If an underflow and an acknowledge coincide, the flag stays set.
- R5: With `pwm_en` = 1, low value n and high value m, `pwm_out` is low for n+1 source periods and high for m+1 source periods, repeating. `pwm_out` is 0 whenever the timer is stopped or `pwm_en` is 0.
- R6: With `pwm_en` = 1 and `ext_en` = 1, each high phase lasts m+1.5 source periods and each low phase still lasts n+1 periods. m must be at least 1.
- R7: With `gate_en` = 1 on a running timer, each one-cycle `gate_pulse` switches `pwm_out` between visible and forced low, starting from visible.
- R8: If `run` is cleared during a high phase, counting continues until that phase ends. The timer then stops, with the counter reloaded from the low register and `pwm_out` low. In any other state, clearing `run` freezes the counter at once.
- R9: Stopping the timer cancels the gating, so a restarted PWM output is visible until the next gate pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_load | input | 1 | Strobe: load counter and low-interval register |
| wr_high | input | 1 | Strobe: load the high-interval register |
| reload | input | 1 | Strobe: copy the low-interval register into the counter |
| wr_data | input | 8 | Data for the load strobes |
| cnt_value | output | 8 | Current counter contents |
| src_a | input | 1 | Count-source level 0 |
| src_b | input | 1 | Count-source level 1 |
| src_sel | input | 1 | Selects the count source |
| run | input | 1 | Run request |
| pwm_en | input | 1 | 1 = PWM mode, 0 = interval timer |
| ext_en | input | 1 | Stretch the high phase by half a period |
| gate_en | input | 1 | Enable output gating |
| gate_pulse | input | 1 | Underflow pulse from another timer |
| irq_ack | input | 1 | Clears the interrupt flag |
| pwm_out | output | 1 | PWM waveform |
| irq_flag | output | 1 | Sticky interrupt flag |
| underflow | output | 1 | One-cycle pulse per underflow |

## Verification
If the phase or reload state is wrong, the waveform period or duty changes on the very next phase boundary, so the measured high and low run lengths show it within one PWM cycle. If the edge-polarity state is wrong in stretch mode, the phase after the stretched high phase gains or loses half a period. A lost stop request shows up as a counter that keeps moving once the high phase has ended. A wrong gate state shows up as a missing or extra high pulse within one full period.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;
  typedef struct packed {
    logic ld_both;
    logic ld_high;
    logic reload;
  } cmd_t;
endpackage

// File: rtl/tmr_edge.sv
module tmr_edge #(
  parameter int NSRC = 2,
  localparam int SELW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic [SELW-1:0] sel,
  output logic            rise,
  output logic            fall
);
  logic lvl, lvl_q;

  assign lvl = src[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/tmr_gate.sv
module tmr_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic gate_en,
  input  logic pulse,
  output logic visible
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 visible <= 1'b1;
    else if (!active || !gate_en) visible <= 1'b1;
    else if (pulse)             visible <= ~visible;
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cmd_t         cmd,
  input  logic [W-1:0] wdata,
  input  logic         run,
  input  logic         pwm_en,
  input  logic         ext_en,
  input  logic         rise,
  input  logic         fall,
  input  logic         irq_ack,
  output logic [W-1:0] cnt,
  output logic         active,
  output logic         high_ph,
  output logic         uf_pulse,
  output logic         irq
);
  logic [W-1:0] cnt_q, lo_q, hi_q;
  logic   act_q, half_q, pol_q, uf_q, irq_q;
  phase_e ph_q;

  logic tick, opp, in_high, stop_now, counting, zero;
  logic uf_hit, start_half, half_end, high_end, uf_evt, load_lo, load_hi;

  always_comb begin
    tick       = pol_q ? fall : rise;
    opp        = pol_q ? rise : fall;
    in_high    = (ph_q == PH_HIGH);
    stop_now   = act_q & ~run & ~(pwm_en & in_high);
    counting   = act_q & ~stop_now;
    zero       = (cnt_q == '0);
    uf_hit     = counting & tick & zero & ~half_q;
    start_half = uf_hit & pwm_en & in_high & ext_en;
    half_end   = counting & half_q & opp;
    high_end   = (uf_hit & pwm_en & in_high & ~ext_en) | half_end;
    uf_evt     = (uf_hit & ~start_half) | half_end;
    load_hi    = uf_hit & pwm_en & ~in_high;
    load_lo    = (uf_hit & ~load_hi & ~start_half) | half_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      act_q  <= 1'b0;
      half_q <= 1'b0;
      pol_q  <= 1'b0;
      uf_q   <= 1'b0;
      irq_q  <= 1'b0;
      ph_q   <= PH_LOW;
    end else begin
      uf_q <= uf_evt;
      if (uf_evt)       irq_q <= 1'b1;
      else if (irq_ack) irq_q <= 1'b0;

      if (cmd.ld_high) hi_q <= wdata;
      if (cmd.ld_both) lo_q <= wdata;

      if (cmd.ld_both)     cnt_q <= wdata;
      else if (cmd.reload) cnt_q <= lo_q;
      else if (load_lo)    cnt_q <= lo_q;
      else if (load_hi)    cnt_q <= hi_q;
      else if (counting & tick & ~zero & ~half_q) cnt_q <= cnt_q - 1'b1;

      if (!act_q) begin
        if (run) begin
          act_q  <= 1'b1;
          ph_q   <= PH_LOW;
          half_q <= 1'b0;
          pol_q  <= 1'b0;
        end
      end else if (stop_now) begin
        act_q  <= 1'b0;
        ph_q   <= PH_LOW;
        half_q <= 1'b0;
        pol_q  <= 1'b0;
      end else begin
        if (!pwm_en)    ph_q   <= PH_LOW;
        else if (load_hi) ph_q <= PH_HIGH;
        if (start_half) half_q <= 1'b1;
        if (high_end) begin
          ph_q   <= PH_LOW;
          half_q <= 1'b0;
          if (half_end) pol_q <= ~pol_q;
          if (!run) begin
            act_q <= 1'b0;
            pol_q <= 1'b0;
          end
        end
      end
    end
  end

  assign cnt      = cnt_q;
  assign active   = act_q;
  assign high_ph  = in_high;
  assign uf_pulse = uf_q;
  assign irq      = irq_q;
endmodule

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_load,
  input  logic         wr_high,
  input  logic         reload,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt_value,
  input  logic         src_a,
  input  logic         src_b,
  input  logic         src_sel,
  input  logic         run,
  input  logic         pwm_en,
  input  logic         ext_en,
  input  logic         gate_en,
  input  logic         gate_pulse,
  input  logic         irq_ack,
  output logic         pwm_out,
  output logic         irq_flag,
  output logic         underflow
);
  localparam int NSRC = 2;

  cmd_t cmd;
  logic rise, fall, core_act, core_high, visible;

  assign cmd = '{ld_both: wr_load, ld_high: wr_high, reload: reload};

  tmr_edge #(.NSRC(NSRC)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .src  ({src_b, src_a}),
    .sel  (src_sel),
    .rise (rise),
    .fall (fall)
  );

  tmr_core #(.W(W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .wdata   (wr_data),
    .run     (run),
    .pwm_en  (pwm_en),
    .ext_en  (ext_en),
    .rise    (rise),
    .fall    (fall),
    .irq_ack (irq_ack),
    .cnt     (cnt_value),
    .active  (core_act),
    .high_ph (core_high),
    .uf_pulse(underflow),
    .irq     (irq_flag)
  );

  tmr_gate u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (core_act),
    .gate_en(gate_en),
    .pulse  (gate_pulse),
    .visible(visible)
  );

  assign pwm_out = core_act & pwm_en & core_high & visible;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_load,
  input logic         reload,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] cnt_value,
  input logic         irq_flag,
  input logic         irq_ack,
  input logic         underflow,
  input logic         act
);
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> (cnt_value == $past(wr_data))); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && !wr_load && !reload) |=> $stable(cnt_value)); // R2

  AST_UF_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> irq_flag); // R4

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (!irq_flag || underflow)); // R4

  AST_NO_UF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> !underflow); // R8
endmodule

bind pwm_reload_timer tmr_checker #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_load  (wr_load),
  .reload   (reload),
  .wr_data  (wr_data),
  .cnt_value(cnt_value),
  .irq_flag (irq_flag),
  .irq_ack  (irq_ack),
  .underflow(underflow),
  .act      (core_act)
);

// File: tb/test_pwm_reload_timer.sv
`timescale 1ns/1ps
module test_pwm_reload_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_load = 0, wr_high = 0, reload = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] cnt_value;
  logic src_a = 0, src_b = 0, src_sel = 0;
  logic run = 0, pwm_en = 0, ext_en = 0, gate_en = 0, gate_pulse = 0, irq_ack = 0;
  logic pwm_out, irq_flag, underflow;

  int compared = 0, mismatched = 0;
  int H = 2;
  bit gen_on = 0, gen_b = 0;
  int hc = 0;
  int run_len = 0, hi_len = -1, lo_len = -1, uf_gap = -1, since = 0;
  logic last_pwm = 0;

  always #2.5 clk = ~clk;

  pwm_reload_timer i_pwm_reload_timer (
    .clk(clk), .rst_n(rst_n), .wr_load(wr_load), .wr_high(wr_high), .reload(reload),
    .wr_data(wr_data), .cnt_value(cnt_value), .src_a(src_a), .src_b(src_b),
    .src_sel(src_sel), .run(run), .pwm_en(pwm_en), .ext_en(ext_en), .gate_en(gate_en),
    .gate_pulse(gate_pulse), .irq_ack(irq_ack), .pwm_out(pwm_out), .irq_flag(irq_flag),
    .underflow(underflow)
  );

  // count-source generator: half period of H clocks
  initial forever begin
    @(negedge clk);
    if (gen_on) begin
      hc++;
      if (hc >= H) begin
        hc = 0;
        if (gen_b) src_b = ~src_b;
        else       src_a = ~src_a;
      end
    end
  end

  // run-length and underflow-gap monitor
  always @(negedge clk) begin
    if (pwm_out === last_pwm) run_len++;
    else begin
      if (last_pwm) hi_len = run_len;
      else          lo_len = run_len;
      run_len = 1;
      last_pwm = pwm_out;
    end
    if (underflow) begin uf_gap = since; since = 1; end
    else since++;
  end

  function automatic int exp_low(int n, int h);
    return (n + 1) * 2 * h;
  endfunction
  function automatic int exp_high(int m, int h, bit ext);
    return (m + 1) * 2 * h + (ext ? h : 0);
  endfunction

  task automatic cyc(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int actv, int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, actv, expv);
    end
  endtask

  task automatic load(int v);
    wr_data = v[7:0]; wr_load = 1; cyc(1); wr_load = 0;
  endtask

  task automatic load_high(int v);
    wr_data = v[7:0]; wr_high = 1; cyc(1); wr_high = 0;
  endtask

  task automatic wait_pwm(logic v);
    for (int i = 0; i < 4000 && pwm_out !== v; i++) cyc(1);
  endtask

  task automatic ack();
    irq_ack = 1; cyc(1); irq_ack = 0;
  endtask

  task automatic timer_trial(int n, int h, bit sel);
    run = 0; gen_on = 0; cyc(2);
    pwm_en = 0; H = h; hc = 0; gen_b = sel; src_sel = sel;
    load(n); ack();
    run = 1; cyc(1); gen_on = 1;
    cyc(exp_low(n, h) * 3 + 10);
    chk(uf_gap == exp_low(n, h), "R3 timer underflow spacing", uf_gap, exp_low(n, h));
    chk(irq_flag == 1, "R4 flag set by underflow", irq_flag, 1);
    run = 0; gen_on = 0; cyc(2);
  endtask

  task automatic pwm_trial(int n, int m, int h, bit ext, bit do_stop);
    int full;
    run = 0; gen_on = 0; cyc(2);
    pwm_en = 1; ext_en = ext; H = h; hc = 0; gen_b = 0; src_sel = 0;
    load(n); load_high(m);
    run = 1; cyc(1); gen_on = 1;
    full = exp_low(n, h) + exp_high(m, h, ext);
    cyc(full * 3 + 20);
    if (ext) begin
      chk(hi_len == exp_high(m, h, 1), "R6 stretched high length", hi_len, exp_high(m, h, 1));
      chk(lo_len == exp_low(n, h), "R6 low length with stretch", lo_len, exp_low(n, h));
    end else begin
      chk(hi_len == exp_high(m, h, 0), "R5 high length", hi_len, exp_high(m, h, 0));
      chk(lo_len == exp_low(n, h), "R5 low length", lo_len, exp_low(n, h));
    end
    if (do_stop) begin
      logic [7:0] snap;
      wait_pwm(1); cyc(2);
      run = 0; cyc(2);
      chk(pwm_out == 1, "R8 high phase continues after stop request", pwm_out, 1);
      wait_pwm(0); cyc(2);
      snap = cnt_value;
      chk(snap == n[7:0], "R8 stopped with low value reloaded", snap, n);
      cyc(6 * h);
      chk(cnt_value == snap && pwm_out == 0, "R8 R5 stopped timer idle low", cnt_value, snap);
    end
    run = 0; gen_on = 0; ext_en = 0; cyc(2); ack();
  endtask

  initial begin
    int n, m, h, full;
    logic [7:0] snap;
    bit seen;
    void'($urandom(32'd20240607));
    cyc(3); rst_n = 1; cyc(1);
    chk(cnt_value == 0, "R1 reset counter", cnt_value, 0);
    chk(pwm_out == 0, "R5 reset output", pwm_out, 0);
    chk(irq_flag == 0, "R4 reset flag", irq_flag, 0);

    load(5);
    chk(cnt_value == 5, "R1 load counter", cnt_value, 5);
    gen_on = 1; cyc(24); gen_on = 0;
    chk(cnt_value == 5, "R2 no count without run", cnt_value, 5);

    // unselected source has no effect
    load(200); src_sel = 0; gen_b = 1; run = 1; cyc(1); gen_on = 1; cyc(30);
    chk(cnt_value == 200, "R2 unselected source ignored", cnt_value, 200);
    gen_on = 0; run = 0; gen_b = 0; cyc(2);

    // timer mode: directed zero boundary and random values on both sources
    timer_trial(0, 2, 0);
    for (int k = 0; k < 4; k++) begin
      n = $urandom_range(1, 12); h = $urandom_range(2, 4);
      timer_trial(n, h, k[0]);
    end
    ack();
    chk(irq_flag == 0, "R4 acknowledge clears flag", irq_flag, 0);

    // partial count, freeze, high write, reload
    H = 2; hc = 0; src_sel = 0; gen_b = 0; pwm_en = 0;
    load(9); run = 1; cyc(1); gen_on = 1; cyc(14); run = 0; gen_on = 0; cyc(2);
    chk(cnt_value < 9, "R2 counter decrements while running", cnt_value, 8);
    snap = cnt_value;
    gen_on = 1; cyc(20); gen_on = 0;
    chk(cnt_value == snap, "R8 immediate freeze in timer mode", cnt_value, snap);
    load_high(77);
    chk(cnt_value == snap, "R1 high write leaves counter", cnt_value, snap);
    reload = 1; cyc(1); reload = 0;
    chk(cnt_value == 9, "R1 reload from low register", cnt_value, 9);

    // PWM: directed minimum, random plain, random stretched
    pwm_trial(0, 0, 2, 0, 0);
    for (int k = 0; k < 2; k++) begin
      n = $urandom_range(0, 8); m = $urandom_range(2, 8); h = $urandom_range(2, 3);
      pwm_trial(n, m, h, 0, 1);
    end
    for (int k = 0; k < 2; k++) begin
      n = $urandom_range(0, 8); m = $urandom_range(2, 8); h = $urandom_range(2, 3);
      pwm_trial(n, m, h, 1, 1);
    end

    // gating
    n = 3; m = 3; H = 2; hc = 0; full = exp_low(n, 2) + exp_high(m, 2, 0);
    pwm_en = 1; gate_en = 1; load(n); load_high(m);
    run = 1; cyc(1); gen_on = 1;
    wait_pwm(1); cyc(1);
    gate_pulse = 1; cyc(1); gate_pulse = 0;
    chk(pwm_out == 0, "R7 gate pulse masks output", pwm_out, 0);
    seen = 0;
    for (int i = 0; i < full * 2; i++) begin cyc(1); if (pwm_out) seen = 1; end
    chk(!seen, "R7 output stays masked", seen, 0);
    gate_pulse = 1; cyc(1); gate_pulse = 0;
    seen = 0;
    for (int i = 0; i < full * 2; i++) begin cyc(1); if (pwm_out) seen = 1; end
    chk(seen, "R7 second pulse restores output", seen, 1);
    gate_pulse = 1; cyc(1); gate_pulse = 0;
    run = 0; cyc(full * 2);
    run = 1; cyc(1);
    seen = 0;
    for (int i = 0; i < full * 2; i++) begin cyc(1); if (pwm_out) seen = 1; end
    chk(seen, "R9 stop cancels gating", seen, 1);
    run = 0; gen_on = 0; gate_en = 0; cyc(full * 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule